// File: doc/BRIEF.md
# ADC Output Test Word Generator

This block sits on the 16-bit sample output path of a data converter and can replace the live conversion result with a known word stream, one word per sample clock. Firmware selects a constant midscale word, either full-scale word, a free-running ramp, or a repeating sequence of up to eight user-loaded words. Setting the mode to off, or to any unassigned code, leaves the live samples flowing through.

Settings are written one byte at a time on a port clocked by a configuration clock that is unrelated to the sample clock. Each write lands in working registers. As soon as the crossing is idle, a complete snapshot of mode, depth and all user words is handed to the sample domain. The snapshot passes through a toggle request, a two-flop synchroniser and an acknowledge. A change of mode or depth restarts the ramp and the user sequence.

Top module: `adc_test_word_gen`

## Requirements
- R1: After reset the mode is off, the depth is 0 and every user word is 0x0000. Selecting the user mode without loading any word therefore yields 0x0000.
- R2: With mode code 0 (bits [7:4] of the byte written to address 0), `smp_dout` equals the `smp_din` value sampled one sample clock earlier.
- R3: Mode code 1 drives a constant 0x8000.
- R4: Mode code 2 drives a constant 0xFFFF, and mode code 3 drives a constant 0x0000.
- R5: User word k (k = 1..8) has its low byte at address 2k-1 and its high byte at address 2k. The depth field is bits [2:0] of the byte at address 0.
- R6: Mode code 8 emits user words 1, 2, ... up to word d+1, where d is the depth, and then wraps back to word 1.
- R7: Mode code 10 emits a ramp that starts at 0x0000, adds one per sample clock, and wraps from 0xFFFF to 0x0000.
- R8: Every other mode code (4-7, 9, 11-15) behaves exactly like mode code 0.
- R9: A published change of mode or depth restarts the ramp at 0x0000 and the user sequence at word 1.
- R10: A control write takes effect within 32 sample clocks, with a 20 ns configuration clock and an 8 ns sample clock. Writes on consecutive configuration cycles are merged, so only the final setting is applied. The snapshot seen by the sample domain never changes while a hand-over is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| cfg_rst_n | input | 1 | Configuration domain reset, active low, asynchronous |
| cfg_we | input | 1 | Byte write strobe |
| cfg_addr | input | AW | Byte address (0 control, 1..16 user words) |
| cfg_wdata | input | 8 | Write byte |
| smp_clk | input | 1 | Sample clock |
| smp_rst_n | input | 1 | Sample domain reset, active low, asynchronous |
| smp_din | input | 16 | Live converter sample |
| smp_dout | output | 16 | Registered output word |

## Verification
The hardest case to reach from the ports is the exact sample clock on which a new setting takes over, because it depends on the phase of two unrelated clocks. The reference model therefore holds each new setting as pending. It keeps accepting the old stream until the output shows the first word of the new one, and a lock-up of 32 cycles counts as a failure. To make that switch point unambiguous, the live data always carries the top nibble 0x3, so it can never match a test word. Mode changes are also ordered so that the old and new streams always differ on the switch cycle. Going from user mode, through ramp, and back to user mode mid-sequence shows the restart. Two control writes on back-to-back configuration cycles show the merging.

// File: rtl/adc_test_word_gen.sv
module adc_test_word_gen #(
  parameter int NPAT = 8,
  parameter int AW   = 5
) (
  input  logic          cfg_clk,
  input  logic          cfg_rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          smp_clk,
  input  logic          smp_rst_n,
  input  logic [15:0]   smp_din,
  output logic [15:0]   smp_dout
);
  localparam int IW = $clog2(NPAT);
  localparam logic [3:0] M_OFF  = 4'd0;
  localparam logic [3:0] M_MID  = 4'd1;
  localparam logic [3:0] M_PFS  = 4'd2;
  localparam logic [3:0] M_NFS  = 4'd3;
  localparam logic [3:0] M_USER = 4'd8;
  localparam logic [3:0] M_RAMP = 4'd10;

  // configuration domain: working registers and published snapshot
  logic [3:0]    mode_w, mode_sh;
  logic [IW-1:0] depth_w, depth_sh;
  logic [15:0]   pat_w  [NPAT];
  logic [15:0]   pat_sh [NPAT];
  logic          dirty, req, ack;
  logic [1:0]    ack_sync;

  always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      mode_w   <= M_OFF;
      depth_w  <= '0;
      mode_sh  <= M_OFF;
      depth_sh <= '0;
      for (int k = 0; k < NPAT; k++) begin
        pat_w[k]  <= '0;
        pat_sh[k] <= '0;
      end
      dirty    <= 1'b0;
      req      <= 1'b0;
      ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[0], ack};
      if (cfg_we) begin
        dirty <= 1'b1;
        if (cfg_addr == '0) begin
          mode_w  <= cfg_wdata[7:4];
          depth_w <= cfg_wdata[IW-1:0];
        end
        for (int k = 0; k < NPAT; k++) begin
          if (cfg_addr == AW'(2*k+1)) pat_w[k][7:0]  <= cfg_wdata;
          if (cfg_addr == AW'(2*k+2)) pat_w[k][15:8] <= cfg_wdata;
        end
      end else if (dirty && (req == ack_sync[1])) begin
        mode_sh  <= mode_w;
        depth_sh <= depth_w;
        pat_sh   <= pat_w;
        req      <= ~req;
        dirty    <= 1'b0;
      end
    end
  end

  // sample domain
  logic [2:0]    req_sync;
  logic [3:0]    mode_s;
  logic [IW-1:0] depth_s, idx;
  logic [15:0]   pat_s [NPAT];
  logic [15:0]   ramp;
  logic          cap, restart;

  assign cap     = req_sync[2] ^ req_sync[1];
  assign restart = cap && ((mode_sh != mode_s) || (depth_sh != depth_s));
  assign ack     = req_sync[2];

  always_ff @(posedge smp_clk or negedge smp_rst_n) begin
    if (!smp_rst_n) begin
      req_sync <= '0;
      mode_s   <= M_OFF;
      depth_s  <= '0;
      for (int k = 0; k < NPAT; k++) pat_s[k] <= '0;
      idx      <= '0;
      ramp     <= '0;
      smp_dout <= '0;
    end else begin
      req_sync <= {req_sync[1:0], req};
      if (cap) begin
        mode_s  <= mode_sh;
        depth_s <= depth_sh;
        pat_s   <= pat_sh;
      end
      case (mode_s)
        M_MID:   smp_dout <= 16'h8000;
        M_PFS:   smp_dout <= 16'hFFFF;
        M_NFS:   smp_dout <= 16'h0000;
        M_USER:  smp_dout <= pat_s[idx];
        M_RAMP:  smp_dout <= ramp;
        default: smp_dout <= smp_din;
      endcase
      if (restart)               idx <= '0;
      else if (mode_s == M_USER) idx <= (idx >= depth_s) ? '0 : IW'(idx + 1'b1);
      if (restart)               ramp <= '0;
      else if (mode_s == M_RAMP) ramp <= ramp + 16'd1;
    end
  end

  assert_shadow_hold_R10: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    (req != ack_sync[1]) |=> ($stable(mode_sh) && $stable(depth_sh)));
  assert_off_pass_R2: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (mode_s == M_OFF) |=> (smp_dout == $past(smp_din)));
  assert_midscale_R3: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (mode_s == M_MID) |=> (smp_dout == 16'h8000));
  assert_fullscale_R4: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (mode_s == M_PFS) |=> (smp_dout == 16'hFFFF));
  assert_idx_range_R6: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (mode_s == M_USER) |-> (idx <= depth_s));
  assert_ramp_step_R7: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (mode_s == M_RAMP && $past(mode_s) == M_RAMP && !$past(restart))
      |=> (smp_dout == $past(smp_dout) + 16'd1));
  assert_ramp_restart_R9: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (restart && mode_sh == M_RAMP) |=> ##1 (smp_dout == 16'h0000));
  assert_user_restart_R9: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
    (restart && mode_sh == M_USER) |=> ##1 (smp_dout == pat_s[0]));
endmodule

// File: tb/sim_adc_test_word_gen.sv
module sim_adc_test_word_gen;
  logic        cfg_clk = 0, smp_clk = 0;
  logic        cfg_rst_n = 0, smp_rst_n = 0;
  logic        cfg_we = 0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] smp_din = 16'h3000;
  logic [15:0] smp_dout;

  adc_test_word_gen u0 (.*);

  always #10 cfg_clk = ~cfg_clk;
  always #4  smp_clk = ~smp_clk;

  int checks = 0, fails = 0, cyc = 0;
  bit chk_en = 0, done = 0;
  string tag = "R1";

  // reference model state
  logic [15:0] m_pat [8];
  int m_mode = 0, m_depth = 0, m_idx = 0, m_ramp = 0;
  bit pend = 0;
  int p_mode = 0, p_depth = 0, p_cnt = 0;
  int k_din = 0;

  function automatic bit passthru(int m);
    return !(m == 1 || m == 2 || m == 3 || m == 8 || m == 10);
  endfunction

  function automatic logic [15:0] word(int m, int ix, int rp, logic [15:0] d);
    case (m)
      1: return 16'h8000;
      2: return 16'hFFFF;
      3: return 16'h0000;
      8: return m_pat[ix];
      10: return 16'(rp);
      default: return d;
    endcase
  endfunction

  always @(negedge smp_clk) begin
    logic [15:0] exp_w;
    if (chk_en && !done) begin
      exp_w = word(m_mode, m_idx, m_ramp, smp_din);
      if (pend) begin
        if (passthru(m_mode) && passthru(p_mode)) begin
          m_mode = p_mode; m_depth = p_depth; pend = 0;
        end else if (smp_dout == word(p_mode, 0, 0, smp_din) && smp_dout != exp_w) begin
          m_mode = p_mode; m_depth = p_depth; m_idx = 0; m_ramp = 0; pend = 0;
          exp_w = word(m_mode, m_idx, m_ramp, smp_din);
        end else begin
          p_cnt++;
          if (p_cnt > 32) begin
            fails++;
            $display("FAIL R10: setting not applied after 32 cycles, dout=%h expected start %h",
                     smp_dout, word(p_mode, 0, 0, smp_din));
            m_mode = p_mode; m_depth = p_depth; m_idx = 0; m_ramp = 0; pend = 0;
          end
        end
      end
      checks++;
      if (smp_dout !== exp_w) begin
        fails++;
        $display("FAIL %s: cycle %0d mode %0d dout=%h expected=%h", tag, cyc, m_mode, smp_dout, exp_w);
      end
      if (m_mode == 8) m_idx = (m_idx >= m_depth) ? 0 : m_idx + 1;
      if (m_mode == 10) m_ramp = (m_ramp + 1) % 65536;
    end
    k_din++;
    smp_din = {4'h3, 12'(k_din * 37 + 5)};
    cyc++;
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge cfg_clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge cfg_clk);
    cfg_we = 0;
    if (a >= 1 && a <= 16) begin
      if (a[0]) m_pat[(a - 1) / 2][7:0] = d;
      else      m_pat[(a - 1) / 2][15:8] = d;
    end
  endtask

  task automatic set_ctl(input int m, input int d);
    wr(5'd0, {4'(m), 1'b0, 3'(d)});
    p_mode = m; p_depth = d; p_cnt = 0; pend = 1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge smp_clk);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) m_pat[k] = '0;
    run(5);
    cfg_rst_n = 1; smp_rst_n = 1;
    @(posedge smp_clk);
    chk_en = 1;
    tag = "R1";                 // reset state: zero user words, depth 0
    set_ctl(8, 0); run(20);
    tag = "R2";
    set_ctl(0, 0); run(30);
    tag = "R5";                 // byte layout of user words
    for (int k = 1; k <= 8; k++) begin
      wr(5'(2*k-1), 8'h50 | 8'(k));
      wr(5'(2*k),   8'hB0 | 8'(k));
    end
    run(20);
    tag = "R6";
    set_ctl(8, 7); run(40);
    set_ctl(0, 0); run(15);
    set_ctl(8, 2); run(30);
    set_ctl(0, 0); run(15);
    set_ctl(8, 0); run(15);
    tag = "R3";
    set_ctl(1, 0); run(25);
    tag = "R4";
    set_ctl(2, 0); run(25);
    set_ctl(3, 0); run(25);
    tag = "R9";
    set_ctl(8, 7); run(37);
    set_ctl(10, 7); run(25);
    set_ctl(8, 7); run(30);
    tag = "R7";
    set_ctl(0, 0); run(15);
    set_ctl(10, 0); run(65536 + 40);
    tag = "R8";
    set_ctl(1, 0); run(20);
    set_ctl(4, 0); run(25);
    set_ctl(2, 0); run(20);
    set_ctl(9, 0); run(25);
    set_ctl(8, 3); run(25);
    set_ctl(15, 0); run(25);
    set_ctl(7, 0); run(25);
    tag = "R10";                // two writes on consecutive cycles merge
    set_ctl(0, 0); run(15);
    @(negedge cfg_clk);
    cfg_we = 1; cfg_addr = 5'd0; cfg_wdata = 8'h83;
    @(negedge cfg_clk);
    cfg_wdata = 8'h20;
    @(negedge cfg_clk);
    cfg_we = 0;
    p_mode = 2; p_depth = 0; p_cnt = 0; pend = 1;
    run(40);
    if (pend) begin
      fails++; checks++;
      $display("FAIL R10: merged setting pending, dout=%h expected=%h", smp_dout, 16'hFFFF);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge smp_clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog R10: run hung, dout=%h expected completion", smp_dout);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule